// File: doc/BRIEF.md
# Counter-Race Oscillator Trim Calibrator

This block centres an on-chip oscillator on an external reference clock of the same nominal frequency by searching an 8-bit capacitor trim code. It compares the two clocks with a race. A counter on the reference clock and a counter on the local clock start together, and the block watches which one finishes its count first. If the local clock wins, the local oscillator is too fast and the code is raised. If the reference wins, the code is lowered. After each step the block clears both counters and waits out a settling interval before the next race starts.

One calibration routine ends when the search has stepped in both directions, which means it has crossed the target frequency. The block runs five routines back to back. Each routine continues from the code the previous one left. The final code is the value that occurs most often among the five results. A bypass select lets the trim code be written directly and holds the race machinery idle. The trim code drives an analog capacitor array, and the final value would normally be stored in nonvolatile memory. Both of those lie outside the block.

Top module: `fcal_engine`

## Requirements
- R1: After reset the trim code is 0x80 (only the top bit set), done and busy are low, and the block stays idle with the code unchanged for as long as enable is low.
- R2: Every race starts from cleared counters: the local counter is held at zero outside the tracking phase, and tracking begins only once the synchronized reference-counter top bit has become set. If the local counter reaches its all-ones terminal count while that bit is still set, the trim code rises by one.
- R3: If the synchronized reference top bit clears while the local counter is still short of terminal count, the trim code falls by one.
- R4: A routine ends on the step that completes a pair of rising and falling steps, or on a race in which terminal count and the clearing of the top bit arrive in the same cycle (the code is then left unchanged). A search that only ever moves one way never completes.
- R5: The trim code saturates at 0x00 and 0xFF and never wraps. The search keeps running while it is pinned at either end.
- R6: A calibration runs exactly five routines. Each routine's result is the code right after its ending step. The final code is the most frequent of the five results, or the fifth result when no single value is strictly most frequent.
- R7: Done stays high, with the code frozen, while enable stays high. Dropping enable at any time returns the block to idle on the next local clock edge, with done and busy low and the code kept.
- R8: Busy is high from the first edge after enable until the final code is loaded, and busy and done are never high together.
- R9: While bypass select is high, the trim code takes the bypass data on each local clock edge, the race logic has no effect, and done and busy are low. When bypass select is low, the bypass data is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_loc | input | 1 | Local oscillator clock; clocks the state machine and the trim register |
| clk_ref | input | 1 | External reference clock; clocks the reference counter |
| rst_n | input | 1 | Asynchronous active-low reset for both clock domains |
| en | input | 1 | Starts a calibration when high; dropping it aborts to idle |
| byp_sel | input | 1 | Selects direct writing of the trim code |
| byp_data | input | TRIM_W | Trim value used while bypass is selected |
| trim | output | TRIM_W | Capacitor trim code |
| done | output | 1 | Final code loaded; held until enable falls |
| busy | output | 1 | Calibration in progress |

## Verification
The assertions assume that enable and bypass select are driven in step with the local clock, and that the reference clock keeps running. They also assume that the local clock is never so fast that the four-cycle settle window plus the wait for the top bit to clear cannot flush a pending clear through the reference domain. The bench drives every input on falling local-clock edges. It models the oscillator with a period that moves in steps of several percent per trim code, which is far coarser than the race can resolve at the bench's counter widths, so races are never near-ties. When the bench shifts the oscillator's target between routines, it does so only after it has seen a routine end at the ports.

// File: rtl/fcal_pkg.sv
package fcal_pkg;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_CLR   = 3'd1,
    S_START = 3'd2,
    S_TRACK = 3'd3,
    S_LOAD  = 3'd4,
    S_DONE  = 3'd5
  } cal_state_e;

endpackage

// File: rtl/fcal_ref_ctr.sv
module fcal_ref_ctr #(
  parameter int W = 12
) (
  input  logic clk_ref,
  input  logic rst_n,
  input  logic clr_req,
  output logic msb
);

  logic         clr_q;
  logic [W-1:0] cnt;

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      clr_q <= 1'b1;
      cnt   <= '0;
    end else begin
      clr_q <= clr_req;
      if (clr_q) cnt <= '0;
      else       cnt <= cnt + 1'b1;
    end
  end

  assign msb = cnt[W-1];

endmodule

// File: rtl/fcal_loc_ctr.sv
module fcal_loc_ctr #(
  parameter int W = 11
) (
  input  logic         clk_loc,
  input  logic         rst_n,
  input  logic         run,
  output logic [W-1:0] cnt,
  output logic         tc
);

  assign tc = &cnt;

  always_ff @(posedge clk_loc or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!run)   cnt <= '0;
    else if (!tc)    cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/fcal_mode_vote.sv
module fcal_mode_vote #(
  parameter int W = 8,
  parameter int N = 5
) (
  input  logic         clk_loc,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         push,
  input  logic [W-1:0] din,
  output logic [W-1:0] winner
);

  localparam int CW = $clog2(N + 1);

  logic [W-1:0]  slot [N];
  logic [CW-1:0] fill;
  logic [CW-1:0] hits [N];

  always_ff @(posedge clk_loc or negedge rst_n) begin
    if (!rst_n)                         fill <= '0;
    else if (clr)                       fill <= '0;
    else if (push && fill != CW'(N))    fill <= fill + 1'b1;
  end

  for (genvar g = 0; g < N; g++) begin : g_slot
    always_ff @(posedge clk_loc or negedge rst_n) begin
      if (!rst_n)                              slot[g] <= '0;
      else if (!clr && push && fill == CW'(g)) slot[g] <= din;
    end

    always_comb begin
      hits[g] = '0;
      for (int j = 0; j < N; j++)
        if (slot[j] == slot[g]) hits[g] = hits[g] + 1'b1;
    end
  end

  always_comb begin
    logic [CW-1:0] best;
    logic [W-1:0]  pick;
    logic          uniq;
    best = '0;
    pick = slot[0];
    uniq = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (hits[i] > best) begin
        best = hits[i];
        pick = slot[i];
        uniq = 1'b1;
      end else if (hits[i] == best && slot[i] != pick) begin
        uniq = 1'b0;
      end
    end
    winner = uniq ? pick : slot[N-1];
  end

endmodule

// File: rtl/fcal_engine.sv
module fcal_engine
  import fcal_pkg::*;
#(
  parameter int TRIM_W = 8,
  parameter int REF_W  = 12,
  parameter int LOC_W  = 11,
  parameter int NRUN   = 5,
  parameter int SETTLE = 4
) (
  input  logic              clk_loc,
  input  logic              clk_ref,
  input  logic              rst_n,
  input  logic              en,
  input  logic              byp_sel,
  input  logic [TRIM_W-1:0] byp_data,
  output logic [TRIM_W-1:0] trim,
  output logic              done,
  output logic              busy
);

  localparam logic [TRIM_W-1:0] TRIM_RST = {1'b1, {(TRIM_W-1){1'b0}}};
  localparam logic [TRIM_W-1:0] TRIM_MAX = '1;
  localparam int RUN_W = $clog2(NRUN + 1);
  localparam int SET_W = $clog2(SETTLE + 1);

  function automatic logic [TRIM_W-1:0] step_up(input logic [TRIM_W-1:0] v);
    return (v == TRIM_MAX) ? v : v + 1'b1;
  endfunction

  function automatic logic [TRIM_W-1:0] step_dn(input logic [TRIM_W-1:0] v);
    return (v == '0) ? v : v - 1'b1;
  endfunction

  cal_state_e        st, st_nx;
  logic              go;
  logic              ref_msb_raw, ref_msb_s;
  logic              ref_clr_req;
  logic              loc_run;
  logic [LOC_W-1:0]  loc_cnt;
  logic              loc_tc;
  logic              in_track;
  logic              ev_inc, ev_dec, ev_tie;
  logic              routine_end, last_run;
  logic              seen_up, seen_dn;
  logic [RUN_W-1:0]  runs;
  logic [SET_W-1:0]  settle_cnt;
  logic              settle_done;
  logic [TRIM_W-1:0] race_trim;
  logic [TRIM_W-1:0] vote;

  assign go          = en && !byp_sel;
  assign ref_clr_req = !(st == S_START || st == S_TRACK);
  assign loc_run     = (st == S_TRACK);
  assign settle_done = (settle_cnt == SET_W'(SETTLE));

  fcal_ref_ctr #(.W(REF_W)) u_ref (
    .clk_ref (clk_ref),
    .rst_n   (rst_n),
    .clr_req (ref_clr_req),
    .msb     (ref_msb_raw)
  );

  fcal_loc_ctr #(.W(LOC_W)) u_loc (
    .clk_loc (clk_loc),
    .rst_n   (rst_n),
    .run     (loc_run),
    .cnt     (loc_cnt),
    .tc      (loc_tc)
  );

  // race decisions
  assign in_track    = go && (st == S_TRACK);
  assign ev_inc      = in_track && loc_tc && ref_msb_s;
  assign ev_dec      = in_track && !loc_tc && !ref_msb_s;
  assign ev_tie      = in_track && loc_tc && !ref_msb_s;
  assign routine_end = ev_tie || (ev_inc && seen_dn) || (ev_dec && seen_up);
  assign last_run    = (runs == RUN_W'(NRUN - 1));

  always_comb begin
    if (ev_inc)      race_trim = step_up(trim);
    else if (ev_dec) race_trim = step_dn(trim);
    else             race_trim = trim;
  end

  fcal_mode_vote #(.W(TRIM_W), .N(NRUN)) u_vote (
    .clk_loc (clk_loc),
    .rst_n   (rst_n),
    .clr     (st == S_IDLE),
    .push    (routine_end),
    .din     (race_trim),
    .winner  (vote)
  );

  always_comb begin
    st_nx = st;
    if (!go) begin
      st_nx = S_IDLE;
    end else begin
      unique case (st)
        S_IDLE:  st_nx = S_CLR;
        S_CLR:   if (settle_done && !ref_msb_s) st_nx = S_START;
        S_START: if (ref_msb_s) st_nx = S_TRACK;
        S_TRACK: begin
          if (routine_end && last_run)         st_nx = S_LOAD;
          else if (ev_inc || ev_dec || ev_tie) st_nx = S_CLR;
        end
        S_LOAD:  st_nx = S_DONE;
        S_DONE:  st_nx = S_DONE;
        default: st_nx = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_loc or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      ref_msb_s <= 1'b0;
    end else begin
      st        <= st_nx;
      ref_msb_s <= ref_msb_raw;
    end
  end

  always_ff @(posedge clk_loc or negedge rst_n) begin
    if (!rst_n)                            settle_cnt <= '0;
    else if (st != S_CLR)                  settle_cnt <= '0;
    else if (!settle_done)                 settle_cnt <= settle_cnt + 1'b1;
  end

  always_ff @(posedge clk_loc or negedge rst_n) begin
    if (!rst_n) begin
      seen_up <= 1'b0;
      seen_dn <= 1'b0;
      runs    <= '0;
    end else if (st == S_IDLE) begin
      seen_up <= 1'b0;
      seen_dn <= 1'b0;
      runs    <= '0;
    end else if (routine_end) begin
      seen_up <= 1'b0;
      seen_dn <= 1'b0;
      runs    <= runs + 1'b1;
    end else begin
      if (ev_inc) seen_up <= 1'b1;
      if (ev_dec) seen_dn <= 1'b1;
    end
  end

  always_ff @(posedge clk_loc or negedge rst_n) begin
    if (!rst_n)                    trim <= TRIM_RST;
    else if (byp_sel)              trim <= byp_data;
    else if (go && st == S_LOAD)   trim <= vote;
    else if (ev_inc || ev_dec)     trim <= race_trim;
  end

  assign done = (st == S_DONE);
  assign busy = (st == S_CLR) || (st == S_START) || (st == S_TRACK) || (st == S_LOAD);

endmodule

// File: rtl/fcal_engine_chk.sv
module fcal_engine_chk
  import fcal_pkg::*;
#(
  parameter int TRIM_W = 8,
  parameter int LOC_W  = 11,
  parameter int RUN_W  = 3,
  parameter int NRUN   = 5
) (
  input logic              clk_loc,
  input logic              rst_n,
  input logic              en,
  input logic              byp_sel,
  input logic [TRIM_W-1:0] byp_data,
  input logic [TRIM_W-1:0] trim,
  input logic              done,
  input logic              busy,
  input cal_state_e        st,
  input logic [LOC_W-1:0]  loc_cnt,
  input logic              ev_inc,
  input logic              ev_dec,
  input logic              ev_tie,
  input logic [RUN_W-1:0]  runs
);

  localparam logic [TRIM_W-1:0] MAXV = '1;

  assert_idle_hold_R1: assert property (@(posedge clk_loc) disable iff (!rst_n)
    (st == S_IDLE && !en) |=> (st == S_IDLE));

  assert_loc_clear_R2: assert property (@(posedge clk_loc) disable iff (!rst_n)
    (st != S_TRACK) |=> (loc_cnt == '0));

  assert_inc_step_R2: assert property (@(posedge clk_loc) disable iff (!rst_n)
    ev_inc |=> (trim == (($past(trim) == MAXV) ? MAXV : TRIM_W'($past(trim) + 1'b1))));

  assert_dec_step_R3: assert property (@(posedge clk_loc) disable iff (!rst_n)
    ev_dec |=> (trim == (($past(trim) == '0) ? '0 : TRIM_W'($past(trim) - 1'b1))));

  assert_one_outcome_R4: assert property (@(posedge clk_loc) disable iff (!rst_n)
    $onehot0({ev_inc, ev_dec, ev_tie}));

  assert_no_wrap_R5: assert property (@(posedge clk_loc) disable iff (!rst_n)
    (!byp_sel && st != S_LOAD) |=>
      (trim == $past(trim) || trim == TRIM_W'($past(trim) + 1'b1) ||
       trim == TRIM_W'($past(trim) - 1'b1)) &&
      !(trim == '0 && $past(trim) == MAXV) && !(trim == MAXV && $past(trim) == '0));

  assert_five_runs_R6: assert property (@(posedge clk_loc) disable iff (!rst_n)
    (st == S_LOAD) |-> (runs == RUN_W'(NRUN)));

  assert_done_hold_R7: assert property (@(posedge clk_loc) disable iff (!rst_n)
    (done && en && !byp_sel) |=> (done && $stable(trim)));

  assert_busy_done_R8: assert property (@(posedge clk_loc) disable iff (!rst_n)
    !(busy && done));

  assert_bypass_R9: assert property (@(posedge clk_loc) disable iff (!rst_n)
    byp_sel |=> (trim == $past(byp_data) && !busy && !done));

endmodule

bind fcal_engine fcal_engine_chk #(
  .TRIM_W (TRIM_W),
  .LOC_W  (LOC_W),
  .RUN_W  (RUN_W),
  .NRUN   (NRUN)
) u_chk (
  .clk_loc  (clk_loc),
  .rst_n    (rst_n),
  .en       (en),
  .byp_sel  (byp_sel),
  .byp_data (byp_data),
  .trim     (trim),
  .done     (done),
  .busy     (busy),
  .st       (st),
  .loc_cnt  (loc_cnt),
  .ev_inc   (ev_inc),
  .ev_dec   (ev_dec),
  .ev_tie   (ev_tie),
  .runs     (runs)
);

// File: tb/sim_fcal_engine.sv
`timescale 1ps/1ps
module sim_fcal_engine;

  logic       clk_ref = 1'b0;
  logic       clk_loc = 1'b0;
  logic       rst_n   = 1'b0;
  logic       en      = 1'b0;
  logic       byp_sel = 1'b0;
  logic [7:0] byp_data = 8'h00;
  logic [7:0] trim;
  logic       done, busy;

  int n_chk  = 0;
  int n_fail = 0;

  // oscillator model: 0 = centred on 'center', 1 = always fast, 2 = always slow
  int osc_mode = 0;
  int center   = 100;

  // routine tracking seen at the ports
  bit trk_on = 1'b0;
  int nres   = 0;
  int res  [5];
  int cents[5];
  bit saw_up = 1'b0;
  bit saw_dn = 1'b0;
  int prev   = 0;

  fcal_engine #(.TRIM_W(8), .REF_W(7), .LOC_W(6), .NRUN(5), .SETTLE(4)) u0 (
    .clk_loc (clk_loc),
    .clk_ref (clk_ref),
    .rst_n   (rst_n),
    .en      (en),
    .byp_sel (byp_sel),
    .byp_data(byp_data),
    .trim    (trim),
    .done    (done),
    .busy    (busy)
  );

  // 125 MHz reference
  always #4000 clk_ref = ~clk_ref;

  function automatic int loc_period(input int t);
    int p;
    if (osc_mode == 1)      p = 5000;
    else if (osc_mode == 2) p = 12000;
    else                    p = 8000 + 800 * (t - center) + 400;
    if (p < 2000)  p = 2000;
    if (p > 30000) p = 30000;
    return p;
  endfunction

  always begin
    #(loc_period(int'(trim)) / 2);
    clk_loc = ~clk_loc;
  end

  always @(negedge clk_loc) begin
    if (trk_on && nres < 5 && int'(trim) != prev) begin
      if (int'(trim) > prev) saw_up = 1'b1;
      else                   saw_dn = 1'b1;
      if (saw_up && saw_dn) begin
        res[nres] = int'(trim);
        nres = nres + 1;
        saw_up = 1'b0;
        saw_dn = 1'b0;
        if (nres < 5) center = cents[nres];
      end
    end
    prev = int'(trim);
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_loc(input int n);
    repeat (n) @(negedge clk_loc);
  endtask

  // most frequent of the five observed results; the last one if no strict winner
  function automatic int bench_mode();
    int top_n, top_v, winners;
    top_n = 0;
    top_v = res[4];
    winners = 0;
    for (int v = 0; v < 256; v++) begin
      int c;
      c = 0;
      for (int k = 0; k < 5; k++) if (res[k] == v) c++;
      if (c > top_n) begin top_n = c; top_v = v; winners = 1; end
      else if (c == top_n && c > 0) winners++;
    end
    return (winners == 1) ? top_v : res[4];
  endfunction

  task automatic run_cal(input int c0, input int c1, input int c2, input int c3, input int c4);
    int guard, idle_seen, fin;
    cents[0] = c0; cents[1] = c1; cents[2] = c2; cents[3] = c3; cents[4] = c4;
    @(negedge clk_loc);
    osc_mode = 0;
    center = c0;
    nres = 0;
    saw_up = 1'b0;
    saw_dn = 1'b0;
    trk_on = 1'b1;
    en = 1'b1;
    wait_loc(2);
    guard = 0;
    idle_seen = 0;
    while (!done && guard < 60000) begin
      if (!busy) idle_seen++;
      @(negedge clk_loc);
      guard++;
    end
    trk_on = 1'b0;
    chk(done == 1'b1, "R4 calibration finished", int'(done), 1);
    chk(nres == 5, "R4 routines seen before done", nres, 5);
    chk(idle_seen == 0, "R8 busy while calibrating", idle_seen, 0);
    chk(busy == 1'b0, "R8 busy low with done", int'(busy), 0);
    for (int k = 0; k < 5; k++)
      chk(res[k] == cents[k] || res[k] == cents[k] - 1, "R6 routine result near target",
          res[k], cents[k]);
    fin = int'(trim);
    chk(fin == bench_mode(), "R6 final code is mode", fin, bench_mode());
    wait_loc(100);
    chk(done == 1'b1, "R7 done held", int'(done), 1);
    chk(int'(trim) == fin, "R7 code frozen after done", int'(trim), fin);
    en = 1'b0;
    wait_loc(2);
    chk(done == 1'b0, "R7 done cleared by enable low", int'(done), 0);
    chk(busy == 1'b0, "R7 idle after enable low", int'(busy), 0);
    chk(int'(trim) == fin, "R7 code kept in idle", int'(trim), fin);
  endtask

  // {select, data, expected trim}
  localparam logic [16:0] BYP_TBL [8] = '{
    {1'b1, 8'h00, 8'h00},
    {1'b1, 8'hFF, 8'hFF},
    {1'b0, 8'h12, 8'hFF},
    {1'b1, 8'h5A, 8'h5A},
    {1'b1, 8'hA5, 8'hA5},
    {1'b0, 8'h33, 8'hA5},
    {1'b1, 8'h01, 8'h01},
    {1'b1, 8'h80, 8'h80}
  };

  initial begin
    #1500000000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int t;
    repeat (12) @(negedge clk_ref);
    chk(trim == 8'h80, "R1 reset trim", int'(trim), 128);
    chk(done == 1'b0, "R1 reset done", int'(done), 0);
    chk(busy == 1'b0, "R1 reset busy", int'(busy), 0);
    @(negedge clk_loc);
    rst_n = 1'b1;
    wait_loc(300);
    chk(trim == 8'h80, "R1 idle without enable keeps code", int'(trim), 128);
    chk(busy == 1'b0, "R1 idle without enable not busy", int'(busy), 0);

    for (int i = 0; i < 8; i++) begin
      byp_sel  = BYP_TBL[i][16];
      byp_data = BYP_TBL[i][15:8];
      wait_loc(1);
      chk(trim == BYP_TBL[i][7:0], "R9 bypass write", int'(trim), int'(BYP_TBL[i][7:0]));
    end
    byp_sel = 1'b0;
    wait_loc(2);

    run_cal(100, 100, 100, 100, 100);
    run_cal(110, 120, 130, 140, 150);
    run_cal(140, 150, 140, 130, 120);

    // pinned high: local always fast
    byp_data = 8'hF8; byp_sel = 1'b1;
    wait_loc(2);
    byp_sel = 1'b0; osc_mode = 1; en = 1'b1;
    wait_loc(300);
    chk(trim > 8'hF8, "R2 fast local raises code", int'(trim), 249);
    wait_loc(4000);
    chk(trim == 8'hFF, "R5 saturates at top", int'(trim), 255);
    chk(busy == 1'b1, "R5 search still running", int'(busy), 1);
    chk(done == 1'b0, "R4 one-way search never completes", int'(done), 0);

    // bypass overrides a running search
    byp_data = 8'h40; byp_sel = 1'b1;
    wait_loc(2);
    chk(trim == 8'h40, "R9 bypass during search", int'(trim), 64);
    chk(busy == 1'b0, "R9 bypass stops search", int'(busy), 0);
    wait_loc(1000);
    chk(trim == 8'h40, "R9 races ignored in bypass", int'(trim), 64);
    byp_sel = 1'b0;

    // abort mid-search
    wait_loc(1000);
    en = 1'b0;
    wait_loc(2);
    t = int'(trim);
    chk(t > 64, "R2 search resumed after bypass", t, 65);
    chk(busy == 1'b0, "R7 abort to idle", int'(busy), 0);
    wait_loc(1000);
    chk(int'(trim) == t, "R7 no change after abort", int'(trim), t);

    // pinned low: local always slow
    byp_data = 8'h06; byp_sel = 1'b1;
    wait_loc(2);
    byp_sel = 1'b0; osc_mode = 2; en = 1'b1;
    wait_loc(150);
    chk(trim < 8'h06, "R3 slow local lowers code", int'(trim), 5);
    wait_loc(1700);
    chk(trim == 8'h00, "R5 saturates at bottom", int'(trim), 0);
    chk(busy == 1'b1, "R5 search continues at bottom", int'(busy), 1);
    en = 1'b0;
    wait_loc(4);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule